// File: doc/BRIEF.md
# Instruction word class decoder

This block takes one 32-bit instruction word and works out how its fields are laid out. The top byte selects a format class. Depending on that class, the remaining 24 bits split into an extended operation code of 8 to 24 bits, up to four 4-bit register selectors, or a signed immediate of 16, 20 or 24 bits. The block sign-extends the immediate to the register width. It raises separate indications for no-operation words, stop words, host service calls and words whose top byte is unassigned.

The decoder logic is purely combinational. A single register stage captures its results whenever the input strobe is high. The registered results appear together with an output strobe on the following cycle and are held until the next strobe. A later stage reads the reserved-slot flag to trap operation codes that fall into unassigned slots of a class that is otherwise defined.

Top module: `opword_decoder`

## Requirements
- R1: `out_vld` is high exactly one cycle after a cycle with `in_vld` high and is low otherwise. Reset clears `out_vld`. While `in_vld` is low, every decoded output keeps its last value.
- R2: `cls_id` gives the class of the top byte, and `cls_oh` has only bit `cls_id` set. The codes are: 0 for 0x00, 1 for 0x01–0x04, 2 for 0x05–0x08, 3 for 0x09–0x0C, 4 for 0x0D, 5 for 0x0E–0x2B, 6 for 0x2C–0x3B, 7 for 0x3C, 8 for 0x42, 10 for 0xFF, and 9 for every other value. `op_byte` repeats the top byte.
- R3: Top byte 0x00 sets `is_nop`. `canon` is set only when the whole word is zero.
- R4: Top byte 0xFF sets `is_halt`. `canon` is set only when the whole word is all ones.
- R5: Class 1 has `xop` equal to bits 23:16. The selectors are `ra`=15:12, `rb`=11:8, `rc`=7:4 and `rd`=3:0. `reg_use`=4'b1111 and `grp` = top byte minus 1.
- R6: Class 2 has `xop` equal to bits 23:12. The selectors are `ra`=11:8, `rb`=7:4 and `rc`=3:0. `reg_use`=4'b0111 and `grp` = top byte minus 5.
- R7: Class 3 has `xop` equal to bits 23:8, with `ra`=7:4 and `rb`=3:0. `reg_use`=4'b0011 and `grp` = top byte minus 9. Class 4 has `xop` equal to bits 23:4, with `ra`=3:0 and `reg_use`=4'b0001.
- R8: Class 5 has `ra`=23:20 and `rb`=19:16. `imm` is bits 15:0 sign-extended to XLEN, `imm_use`=1 and `reg_use`=4'b0011.
- R9: Class 6 has `ra`=23:20, `imm` equal to bits 19:0 sign-extended, and `reg_use`=4'b0001. Class 7 has `imm` equal to bits 23:0 sign-extended and `reg_use`=0. Both classes set `imm_use`.
- R10: Class 8 sets `is_hal`, with `xop` equal to bits 23:0. It has no selectors and no immediate.
- R11: Class 9 sets `warn` and carries no operation code, selectors or immediate.
- R12: `rsv_sub` is raised in several cases. In group 3 of classes 1–3, it is always raised. In group 0, it is raised when `xop` falls outside the assigned slots: class 1 above 0x13; class 2 at 0x00E–0x00F, 0x01C–0x01F, 0x029–0x02F or above 0x037; class 3 outside 0x0000–0x0005 and 0x0100–0x0101; class 4 outside 0x00000–0x00003, 0x01000–0x01001 and 0x02000–0x02001. It is also raised for top bytes 0x1A–0x1E, 0x27–0x2B and 0x37–0x3B. It is low in all other cases.
- R13: `reg_use` bit 0/1/2/3 marks `ra`/`rb`/`rc`/`rd`. A selector whose bit is clear reads zero. `xop` reads zero in classes without one, and `imm` reads zero when `imm_use` is low. `grp` is zero outside classes 1–3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Capture strobe for `in_word` |
| in_word | input | 32 | Instruction word |
| out_vld | output | 1 | Decoded fields valid |
| cls_id | output | 4 | Class code |
| cls_oh | output | 11 | One-hot class flags |
| grp | output | 2 | Group inside a multi-group class |
| op_byte | output | 8 | Top byte of the word |
| xop | output | 24 | Extended operation code, zero-extended |
| ra | output | 4 | First register selector |
| rb | output | 4 | Second register selector |
| rc | output | 4 | Third register selector |
| rd | output | 4 | Fourth register selector |
| reg_use | output | 4 | Selector valid mask |
| imm | output | XLEN | Sign-extended immediate |
| imm_use | output | 1 | Immediate present |
| is_nop | output | 1 | No-operation word |
| is_halt | output | 1 | Stop word |
| canon | output | 1 | Word is the exact canonical form |
| is_hal | output | 1 | Host service call |
| warn | output | 1 | Unassigned top byte |
| rsv_sub | output | 1 | Unassigned slot inside a defined class |

## Verification
The bench builds the block with XLEN set to 48. At that width, each sign extension must fill 32, 28 or 24 bits above the source field. An immediate that is truncated or zero-filled therefore shows up in bits that a 32-bit build would partly hide. The chosen words sit on both sides of every reserved-slot edge and cover negative and positive immediates at their extreme values. The sequence includes back-to-back strobes, idle gaps with junk on the input, and a reset asserted while a strobe is pending.

// File: rtl/opdec_pkg.sv
package opdec_pkg;
  localparam int WORD_W = 32;
  localparam int RIDX_W = 4;
  localparam int XOP_W  = 24;
  localparam int NCLS   = 11;
  localparam int NREG   = 4;

  typedef enum logic [3:0] {
    CL_NOP  = 4'd0,
    CL_R4   = 4'd1,
    CL_R3   = 4'd2,
    CL_R2   = 4'd3,
    CL_R1   = 4'd4,
    CL_I16  = 4'd5,
    CL_I20  = 4'd6,
    CL_I24  = 4'd7,
    CL_HAL  = 4'd8,
    CL_RSV  = 4'd9,
    CL_HALT = 4'd10
  } cls_e;

  // immediate width selector: 0 none, 1 = 16 bits, 2 = 20 bits, 3 = 24 bits
  typedef struct packed {
    logic [XOP_W-1:0]  xop;
    logic [RIDX_W-1:0] ra;
    logic [RIDX_W-1:0] rb;
    logic [RIDX_W-1:0] rc;
    logic [RIDX_W-1:0] rd;
    logic [NREG-1:0]   use_m;
    logic [XOP_W-1:0]  imm_raw;
    logic [1:0]        imm_kind;
  } fld_t;
endpackage

// File: rtl/opdec_class.sv
module opdec_class
  import opdec_pkg::*;
(
  input  logic [7:0] top_b,
  output cls_e       cls,
  output logic [1:0] grp
);
  // the three grouped classes start at bases ending in binary 01,
  // so the group number is the low two bits minus one
  logic [1:0] grp_off;
  assign grp_off = top_b[1:0] - 2'd1;

  always_comb begin
    grp = 2'd0;
    if (top_b == 8'h00) begin
      cls = CL_NOP;
    end else if (top_b == 8'hFF) begin
      cls = CL_HALT;
    end else if (top_b <= 8'h04) begin
      cls = CL_R4;
      grp = grp_off;
    end else if (top_b <= 8'h08) begin
      cls = CL_R3;
      grp = grp_off;
    end else if (top_b <= 8'h0C) begin
      cls = CL_R2;
      grp = grp_off;
    end else if (top_b == 8'h0D) begin
      cls = CL_R1;
    end else if (top_b <= 8'h2B) begin
      cls = CL_I16;
    end else if (top_b <= 8'h3B) begin
      cls = CL_I20;
    end else if (top_b == 8'h3C) begin
      cls = CL_I24;
    end else if (top_b == 8'h42) begin
      cls = CL_HAL;
    end else begin
      cls = CL_RSV;
    end
  end
endmodule

// File: rtl/opdec_fields.sv
module opdec_fields
  import opdec_pkg::*;
(
  input  logic [23:0] body,
  input  cls_e        cls,
  output fld_t        f
);
  always_comb begin
    f = '0;
    case (cls)
      CL_R4: begin
        f.xop   = {16'h0000, body[23:16]};
        f.ra    = body[15:12];
        f.rb    = body[11:8];
        f.rc    = body[7:4];
        f.rd    = body[3:0];
        f.use_m = 4'b1111;
      end
      CL_R3: begin
        f.xop   = {12'h000, body[23:12]};
        f.ra    = body[11:8];
        f.rb    = body[7:4];
        f.rc    = body[3:0];
        f.use_m = 4'b0111;
      end
      CL_R2: begin
        f.xop   = {8'h00, body[23:8]};
        f.ra    = body[7:4];
        f.rb    = body[3:0];
        f.use_m = 4'b0011;
      end
      CL_R1: begin
        f.xop   = {4'h0, body[23:4]};
        f.ra    = body[3:0];
        f.use_m = 4'b0001;
      end
      CL_I16: begin
        f.ra       = body[23:20];
        f.rb       = body[19:16];
        f.imm_raw  = {8'h00, body[15:0]};
        f.imm_kind = 2'd1;
        f.use_m    = 4'b0011;
      end
      CL_I20: begin
        f.ra       = body[23:20];
        f.imm_raw  = {4'h0, body[19:0]};
        f.imm_kind = 2'd2;
        f.use_m    = 4'b0001;
      end
      CL_I24: begin
        f.imm_raw  = body;
        f.imm_kind = 2'd3;
      end
      CL_HAL: begin
        f.xop = body;
      end
      default: begin
      end
    endcase
  end
endmodule

// File: rtl/opdec_sext.sv
module opdec_sext #(
  parameter int XLEN = 32
) (
  input  logic [23:0]     raw,
  input  logic [1:0]      kind,
  output logic [XLEN-1:0] imm
);
  localparam int NW = 3;
  logic [XLEN-1:0] cand [0:NW-1];

  // one candidate per immediate width: 16, 20, 24 bits
  for (genvar k = 0; k < NW; k++) begin : g_w
    localparam int W = 16 + 4 * k;
    assign cand[k] = {{(XLEN-W){raw[W-1]}}, raw[W-1:0]};
  end

  always_comb begin
    case (kind)
      2'd1:    imm = cand[0];
      2'd2:    imm = cand[1];
      2'd3:    imm = cand[2];
      default: imm = '0;
    endcase
  end
endmodule

// File: rtl/opdec_rsv.sv
module opdec_rsv
  import opdec_pkg::*;
(
  input  cls_e        cls,
  input  logic [1:0]  grp,
  input  logic [7:0]  top_b,
  input  logic [23:0] xop,
  output logic        rsv
);
  localparam logic [23:0] R4_LAST = 24'h000013;
  localparam logic [23:0] R3_LAST = 24'h000037;
  localparam logic [1:0]  GRP_INT = 2'd0;
  localparam logic [1:0]  GRP_RSV = 2'd3;

  function automatic logic in_rng(input logic [23:0] v, input logic [23:0] lo,
                                  input logic [23:0] hi);
    return (v >= lo) && (v <= hi);
  endfunction

  logic r3_hole, r2_free, r1_free;
  assign r3_hole = in_rng(xop, 24'h00000E, 24'h00000F) ||
                   in_rng(xop, 24'h00001C, 24'h00001F) ||
                   in_rng(xop, 24'h000029, 24'h00002F) ||
                   (xop > R3_LAST);
  assign r2_free = !(in_rng(xop, 24'h000000, 24'h000005) ||
                     in_rng(xop, 24'h000100, 24'h000101));
  assign r1_free = !(in_rng(xop, 24'h000000, 24'h000003) ||
                     in_rng(xop, 24'h001000, 24'h001001) ||
                     in_rng(xop, 24'h002000, 24'h002001));

  always_comb begin
    rsv = 1'b0;
    case (cls)
      CL_R4:  rsv = (grp == GRP_RSV) || ((grp == GRP_INT) && (xop > R4_LAST));
      CL_R3:  rsv = (grp == GRP_RSV) || ((grp == GRP_INT) && r3_hole);
      CL_R2:  rsv = (grp == GRP_RSV) || ((grp == GRP_INT) && r2_free);
      CL_R1:  rsv = r1_free;
      CL_I16: rsv = in_rng({16'h0, top_b}, 24'h1A, 24'h1E) ||
                    in_rng({16'h0, top_b}, 24'h27, 24'h2B);
      CL_I20: rsv = in_rng({16'h0, top_b}, 24'h37, 24'h3B);
      default: rsv = 1'b0;
    endcase
  end
endmodule

// File: rtl/opword_decoder.sv
module opword_decoder #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_vld,
  input  logic [31:0]     in_word,
  output logic            out_vld,
  output logic [3:0]      cls_id,
  output logic [10:0]     cls_oh,
  output logic [1:0]      grp,
  output logic [7:0]      op_byte,
  output logic [23:0]     xop,
  output logic [3:0]      ra,
  output logic [3:0]      rb,
  output logic [3:0]      rc,
  output logic [3:0]      rd,
  output logic [3:0]      reg_use,
  output logic [XLEN-1:0] imm,
  output logic            imm_use,
  output logic            is_nop,
  output logic            is_halt,
  output logic            canon,
  output logic            is_hal,
  output logic            warn,
  output logic            rsv_sub
);
  import opdec_pkg::*;

  logic [7:0]      top_b;
  logic [23:0]     body;
  cls_e            cls_c;
  logic [1:0]      grp_c;
  fld_t            fld_c;
  logic [XLEN-1:0] imm_c;
  logic            rsv_c;
  logic [NCLS-1:0] oh_c;
  logic            canon_c;

  assign top_b = in_word[31:24];
  assign body  = in_word[23:0];

  opdec_class u_class (
    .top_b (top_b),
    .cls   (cls_c),
    .grp   (grp_c)
  );

  opdec_fields u_fields (
    .body (body),
    .cls  (cls_c),
    .f    (fld_c)
  );

  opdec_sext #(.XLEN(XLEN)) u_sext (
    .raw  (fld_c.imm_raw),
    .kind (fld_c.imm_kind),
    .imm  (imm_c)
  );

  opdec_rsv u_rsv (
    .cls   (cls_c),
    .grp   (grp_c),
    .top_b (top_b),
    .xop   (fld_c.xop),
    .rsv   (rsv_c)
  );

  assign oh_c    = NCLS'(1) << cls_c;
  assign canon_c = ((cls_c == CL_NOP)  && (body == 24'h000000)) ||
                   ((cls_c == CL_HALT) && (body == 24'hFFFFFF));

  always_ff @(posedge clk) begin
    if (rst) out_vld <= 1'b0;
    else     out_vld <= in_vld;
  end

  // data path registers carry no reset: only the strobe is cleared
  always_ff @(posedge clk) begin
    if (in_vld) begin
      cls_id  <= cls_c;
      cls_oh  <= oh_c;
      grp     <= grp_c;
      op_byte <= top_b;
      xop     <= fld_c.xop;
      ra      <= fld_c.ra;
      rb      <= fld_c.rb;
      rc      <= fld_c.rc;
      rd      <= fld_c.rd;
      reg_use <= fld_c.use_m;
      imm     <= imm_c;
      imm_use <= (fld_c.imm_kind != 2'd0);
      is_nop  <= (cls_c == CL_NOP);
      is_halt <= (cls_c == CL_HALT);
      canon   <= canon_c;
      is_hal  <= (cls_c == CL_HAL);
      warn    <= (cls_c == CL_RSV);
      rsv_sub <= rsv_c;
    end
  end
endmodule

// File: rtl/opdec_chk.sv
module opdec_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            in_vld,
  input logic            out_vld,
  input logic [3:0]      cls_id,
  input logic [10:0]     cls_oh,
  input logic [7:0]      op_byte,
  input logic [23:0]     xop,
  input logic [3:0]      rd,
  input logic [3:0]      reg_use,
  input logic [XLEN-1:0] imm,
  input logic            imm_use,
  input logic            is_nop,
  input logic            is_halt,
  input logic            canon,
  input logic            is_hal,
  input logic            warn,
  input logic            rsv_sub
);
  p_vld_next_r1: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld);

  p_vld_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !out_vld);

  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> ($stable(xop) && $stable(cls_id) && $stable(imm)));

  p_cls_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> ($countones(cls_oh) == 1));

  p_nop_byte_r3: assert property (@(posedge clk) disable iff (rst)
    (out_vld && is_nop) |-> (op_byte == 8'h00));

  p_canon_kind_r3: assert property (@(posedge clk) disable iff (rst)
    (out_vld && canon) |-> (is_nop || is_halt));

  p_halt_byte_r4: assert property (@(posedge clk) disable iff (rst)
    (out_vld && is_halt) |-> (op_byte == 8'hFF && reg_use == 4'b0000));

  p_i16_sext_r8: assert property (@(posedge clk) disable iff (rst)
    (out_vld && cls_oh[5]) |-> (imm[XLEN-1:15] == '0 || (&imm[XLEN-1:15])));

  p_i20_sext_r9: assert property (@(posedge clk) disable iff (rst)
    (out_vld && cls_oh[6]) |-> (imm[XLEN-1:19] == '0 || (&imm[XLEN-1:19])));

  p_hal_bare_r10: assert property (@(posedge clk) disable iff (rst)
    (out_vld && is_hal) |-> (reg_use == 4'b0000 && !imm_use));

  p_rsv_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (out_vld && warn) |-> (xop == 24'h0 && reg_use == 4'b0000 && !rsv_sub));

  p_rsv_scope_r12: assert property (@(posedge clk) disable iff (rst)
    (out_vld && rsv_sub) |-> (!is_nop && !is_halt && !is_hal && !warn));

  p_unused_zero_r13: assert property (@(posedge clk) disable iff (rst)
    (out_vld && !reg_use[3]) |-> (rd == 4'h0));

  p_imm_zero_r13: assert property (@(posedge clk) disable iff (rst)
    (out_vld && !imm_use) |-> (imm == '0));
endmodule

bind opword_decoder opdec_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/sim_opword_decoder.sv
`timescale 1ns/1ps
module sim_opword_decoder;
  localparam int XLEN = 48;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_vld = 1'b0;
  logic [31:0]     in_word = 32'h0;
  logic            out_vld;
  logic [3:0]      cls_id;
  logic [10:0]     cls_oh;
  logic [1:0]      grp;
  logic [7:0]      op_byte;
  logic [23:0]     xop;
  logic [3:0]      ra, rb, rc, rd, reg_use;
  logic [XLEN-1:0] imm;
  logic            imm_use, is_nop, is_halt, canon, is_hal, warn, rsv_sub;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  opword_decoder #(.XLEN(XLEN)) u0 (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_word(in_word),
    .out_vld(out_vld), .cls_id(cls_id), .cls_oh(cls_oh), .grp(grp),
    .op_byte(op_byte), .xop(xop), .ra(ra), .rb(rb), .rc(rc), .rd(rd),
    .reg_use(reg_use), .imm(imm), .imm_use(imm_use), .is_nop(is_nop),
    .is_halt(is_halt), .canon(canon), .is_hal(is_hal), .warn(warn),
    .rsv_sub(rsv_sub)
  );

  typedef struct {
    logic [31:0]     w;
    int              c;
    logic [1:0]      grp;
    logic [23:0]     xop;
    logic [3:0]      ra, rb, rc, rd, use_m;
    logic [XLEN-1:0] imm;
    logic            imm_use, nop, halt, canon, hal, warn, rsv;
    string           tag;
  } exp_t;

  exp_t q[$];
  exp_t last;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // reference model written from the requirement list
  function automatic exp_t model(input logic [31:0] w);
    exp_t e;
    int b;
    logic signed [XLEN-1:0] sx;
    logic [23:0] x;
    b = int'(w[31:24]);
    e.w = w; e.c = 9; e.grp = 2'd0; e.xop = 24'h0;
    e.ra = 4'h0; e.rb = 4'h0; e.rc = 4'h0; e.rd = 4'h0; e.use_m = 4'h0;
    e.imm = '0; e.imm_use = 1'b0; e.nop = 1'b0; e.halt = 1'b0;
    e.canon = 1'b0; e.hal = 1'b0; e.warn = 1'b0; e.rsv = 1'b0; e.tag = "R11";
    if (b == 0) begin
      e.c = 0; e.nop = 1'b1; e.canon = (w == 32'h0); e.tag = "R3";
    end else if (b == 255) begin
      e.c = 10; e.halt = 1'b1; e.canon = (w == 32'hFFFF_FFFF); e.tag = "R4";
    end else if (b >= 1 && b <= 4) begin
      e.c = 1; e.grp = 2'(b - 1); e.tag = "R5";
      e.xop = {16'h0, w[23:16]};
      {e.ra, e.rb, e.rc, e.rd} = w[15:0]; e.use_m = 4'b1111;
      e.rsv = (e.grp == 2'd3) || (e.grp == 2'd0 && w[23:16] >= 8'h14);
    end else if (b >= 5 && b <= 8) begin
      e.c = 2; e.grp = 2'(b - 5); e.tag = "R6";
      x = {12'h0, w[23:12]}; e.xop = x;
      {e.ra, e.rb, e.rc} = w[11:0]; e.use_m = 4'b0111;
      e.rsv = (e.grp == 2'd3) ||
              (e.grp == 2'd0 && !(x <= 24'h0D || (x >= 24'h10 && x <= 24'h1B) ||
                                  (x >= 24'h20 && x <= 24'h28) ||
                                  (x >= 24'h30 && x <= 24'h37)));
    end else if (b >= 9 && b <= 12) begin
      e.c = 3; e.grp = 2'(b - 9); e.tag = "R7";
      x = {8'h0, w[23:8]}; e.xop = x;
      {e.ra, e.rb} = w[7:0]; e.use_m = 4'b0011;
      e.rsv = (e.grp == 2'd3) ||
              (e.grp == 2'd0 && !(x < 24'h6 || x == 24'h100 || x == 24'h101));
    end else if (b == 13) begin
      e.c = 4; e.tag = "R7";
      x = {4'h0, w[23:4]}; e.xop = x;
      e.ra = w[3:0]; e.use_m = 4'b0001;
      e.rsv = !(x < 24'h4 || x == 24'h1000 || x == 24'h1001 ||
                x == 24'h2000 || x == 24'h2001);
    end else if (b >= 14 && b <= 43) begin
      e.c = 5; e.tag = "R8";
      e.ra = w[23:20]; e.rb = w[19:16]; e.use_m = 4'b0011;
      sx = $signed(w[15:0]); e.imm = sx; e.imm_use = 1'b1;
      e.rsv = (b >= 26 && b <= 30) || (b >= 39 && b <= 43);
    end else if (b >= 44 && b <= 59) begin
      e.c = 6; e.tag = "R9";
      e.ra = w[23:20]; e.use_m = 4'b0001;
      sx = $signed(w[19:0]); e.imm = sx; e.imm_use = 1'b1;
      e.rsv = (b >= 55);
    end else if (b == 60) begin
      e.c = 7; e.tag = "R9";
      sx = $signed(w[23:0]); e.imm = sx; e.imm_use = 1'b1;
    end else if (b == 66) begin
      e.c = 8; e.tag = "R10"; e.hal = 1'b1; e.xop = w[23:0];
    end else begin
      e.warn = 1'b1;
    end
    return e;
  endfunction

  // monitor: pops one expected item per valid output
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && out_vld) begin
        if (q.size() == 0) begin
          chk("R1", "unexpected out_vld", 64'd1, 64'd0);
        end else begin
          exp_t e;
          logic [10:0] oh;
          e = q.pop_front();
          oh = '0; oh[e.c] = 1'b1;
          chk("R2", "cls_id", 64'(cls_id), 64'(e.c));
          chk("R2", "cls_oh", 64'(cls_oh), 64'(oh));
          chk("R2", "op_byte", 64'(op_byte), 64'(e.w[31:24]));
          chk(e.tag, "grp", 64'(grp), 64'(e.grp));
          chk(e.tag, "xop", 64'(xop), 64'(e.xop));
          chk(e.tag, "regs", 64'({ra, rb, rc, rd}), 64'({e.ra, e.rb, e.rc, e.rd}));
          chk(e.tag, "reg_use", 64'(reg_use), 64'(e.use_m));
          chk(e.tag, "imm", 64'(imm), 64'(e.imm));
          chk(e.tag, "imm_use", 64'(imm_use), 64'(e.imm_use));
          chk("R3", "is_nop", 64'(is_nop), 64'(e.nop));
          chk("R4", "is_halt", 64'(is_halt), 64'(e.halt));
          chk(e.tag, "canon", 64'(canon), 64'(e.canon));
          chk("R10", "is_hal", 64'(is_hal), 64'(e.hal));
          chk("R11", "warn", 64'(warn), 64'(e.warn));
          chk("R12", "rsv_sub", 64'(rsv_sub), 64'(e.rsv));
          chk("R13", "unused selectors", 64'({ra & {4{~reg_use[0]}}, rb & {4{~reg_use[1]}},
                                             rc & {4{~reg_use[2]}}, rd & {4{~reg_use[3]}}}), 64'd0);
          last = e;
        end
      end
    end
  end

  task automatic send(input logic [31:0] w);
    q.push_back(model(w));
    in_vld  = 1'b1;
    in_word = w;
    @(negedge clk);
  endtask

  task automatic idle(input logic [31:0] junk);
    in_vld  = 1'b0;
    in_word = junk;
    @(negedge clk);
  endtask

  // R1: outputs hold while the strobe is low
  task automatic hold_chk(input logic [31:0] w, input logic [31:0] junk);
    send(w);
    idle(junk);
    idle(~junk);
    chk("R1", "out_vld low in gap", 64'(out_vld), 64'd0);
    chk("R1", "xop held", 64'(xop), 64'(last.xop));
    chk("R1", "imm held", 64'(imm), 64'(last.imm));
    chk("R1", "cls held", 64'(cls_id), 64'(last.c));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk("R1", "out_vld in reset", 64'(out_vld), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "out_vld after reset", 64'(out_vld), 64'd0);

    // R3 / R4: canonical and non-canonical forms
    send(32'h0000_0000);
    send(32'h0012_3456);
    send(32'hFFFF_FFFF);
    send(32'hFF00_0001);
    idle(32'h1234_5678);
    // R5 four-operand, R12 edges
    send(32'h0113_1234);
    send(32'h0114_5678);
    send(32'h0200_ABCD);
    send(32'h04FF_0000);
    // R6 three-operand
    send(32'h0503_7ABC);
    send(32'h0503_8ABC);
    send(32'h0500_DABC);
    send(32'h0500_EABC);
    send(32'h0502_8123);
    send(32'h0502_9123);
    send(32'h0801_2345);
    send(32'h0600_0000);
    // R7 two-operand and one-operand
    send(32'h0900_05AB);
    send(32'h0900_06AB);
    send(32'h0901_01AB);
    send(32'h0901_02AB);
    send(32'h0A12_3456);
    send(32'h0D02_001F);
    send(32'h0D02_002F);
    send(32'h0D00_003A);
    send(32'h0D00_004A);
    idle(32'hDEAD_BEEF);
    // R8 16-bit immediates
    send(32'h0E12_FFFE);
    send(32'h137F_7FFF);
    send(32'h1980_0000);
    send(32'h1A00_0000);
    send(32'h1F12_3456);
    send(32'h2B34_5678);
    // R9 20- and 24-bit immediates
    send(32'h2C98_0000);
    send(32'h367F_FFFF);
    send(32'h3700_0000);
    send(32'h3C80_0000);
    send(32'h3C7F_FFFF);
    // R10 host call, R11 unassigned bytes
    send(32'h4210_0200);
    send(32'h3D00_0000);
    send(32'h41FF_FFFF);
    send(32'h4312_3456);
    send(32'hFE00_0000);
    hold_chk(32'h2C5F_FFFF, 32'h0112_3456);
    hold_chk(32'h0E00_8000, 32'hFFFF_FFFF);

    // R1: reset while a strobe is pending
    in_vld = 1'b1; in_word = 32'h0501_0ABC; rst = 1'b1;
    @(negedge clk);
    in_vld = 1'b0; rst = 1'b0;
    @(negedge clk);
    chk("R1", "strobe during reset dropped", 64'(out_vld), 64'd0);

    idle(32'h0);
    idle(32'h0);
    chk("R1", "all results delivered", 64'(q.size()), 64'd0);
    finish_run();
  end
endmodule